// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the 32-bit time base that a serial-bus link layer uses to pace its isochronous traffic. The value is split into three fields. A 12-bit offset counts clock ticks inside one isochronous cycle. A 13-bit cycle count counts cycles inside one second. A 7-bit seconds field counts seconds. The offset advances only while the timer is enabled.

The cycle count can be paced in one of two ways. By default it advances each time the offset wraps. When the external source is selected, it advances instead on each rising edge of an external cycle pulse, and that edge also clears the offset. The external pulse is synchronized inside the block before its edge is detected.

When the node has been made cycle master by a control write and the root-status input is high, every advance of the cycle count raises a single-cycle request to send a cycle-start packet. Host software can load all three fields at once through a write port.

Top module: `isoc_cycle_timer`

## Requirements
- R1: The offset (cyc_time[11:0]) increases by one on each clock while tmr_en is high. While tmr_en is low it holds its value, unless a host write or an external cycle edge changes it.
- R2: With ext_src_sel low and tmr_en high, an offset of 3071 goes to 0 on the next clock and the cycle count (cyc_time[24:12]) increases by one. An offset never exceeds 3071.
- R3: With ext_src_sel high, an offset wrap leaves the cycle count unchanged. A rising edge on ext_cycle changes the timer on the third clock edge after the input rises: the cycle count increases by one and the offset becomes 0. With ext_src_sel low, ext_cycle has no effect.
- R4: An ext_cycle input held high produces exactly one cycle-count increase.
- R5: A cycle count of 7999 goes to 0 when it advances, and the seconds field (cyc_time[31:25]) then increases by one. A seconds value of 127 wraps to 0. A cycle count never exceeds 7999.
- R6: A host write (host_wr) loads seconds from host_wdata[31:25], the cycle count from [24:12] and the offset from [11:0] on the next clock. The write takes precedence over any increment in the same clock, and no cycle-start request results from it.
- R7: cycle_start_req is high for exactly one clock, in the clock in which the new cycle count is first visible. It is raised only if the master bit is set and root was high when the advance was taken.
- R8: The master bit changes only on a control write (ctl_wr, value ctl_master). It keeps its value across timer wraps, loads and external edges.
- R9: After rst_n is asserted low, cyc_time is 0, cycle_start_req is 0 and the master bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Offset count enable |
| ext_src_sel | input | 1 | 1: cycle count paced by ext_cycle; 0: paced by offset wrap |
| ext_cycle | input | 1 | External cycle pulse, asynchronous |
| root | input | 1 | High while the node is bus root |
| ctl_wr | input | 1 | Control write strobe for the master bit |
| ctl_master | input | 1 | Master bit value written by ctl_wr |
| host_wr | input | 1 | Timer load strobe |
| host_wdata | input | 32 | Timer load value {seconds, count, offset} |
| cyc_time | output | 32 | Current timer value {seconds, count, offset} |
| cycle_start_req | output | 1 | One-clock request to send a cycle-start packet |

## Verification
The offset is exercised in several ways: held with the enable low, stepped with it high, and taken across its wrap under both pacing sources. This separates an enable fault from a wrap fault, and an internal-pace fault from an external-pace fault. The external pulse is tried in three forms: a single edge timed to the exact clock of its effect, a long high level, and a pulse while the internal source is selected. Together these show the edge detection, its latency and the source gating. Loads are placed on the clock where a wrap would occur, and on the nested seconds wrap. Requests are watched under each combination of master bit and root status, and after the master bit is written both ways.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

  // Reason the cycle count moved in a given clock.
  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_ROLL = 2'd1,
    ADV_EXT  = 2'd2,
    ADV_LOAD = 2'd3
  } adv_src_e;

  // Next value of a wrapping field counter, widths up to 16 bits.
  function automatic logic [15:0] wrap_next(input logic [15:0] cur,
                                            input logic [15:0] max);
    return (cur >= max) ? 16'd0 : cur + 16'd1;
  endfunction

  // Pack the three fields into one timer word.
  function automatic logic [31:0] pack_time(input logic [6:0]  sec,
                                            input logic [12:0] cnt,
                                            input logic [11:0] off);
    return {sec, cnt, off};
  endfunction

endpackage

// File: rtl/cyc_edge_sync.sv
module cyc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign rise = chain[LAST] & ~prev_q;
endmodule

// File: rtl/cyc_field_ctr.sv
module cyc_field_ctr
  import cyc_timer_pkg::*;
#(
  parameter int W   = 12,
  parameter int MAX = 3071
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         at_max
);
  localparam logic [15:0] MAX16 = 16'(MAX);

  logic [W-1:0] nxt;
  logic [15:0]  cur16;
  logic [15:0]  inc16;

  assign cur16  = 16'(value);
  assign inc16  = wrap_next(cur16, MAX16);
  assign at_max = (cur16 == MAX16);

  always_comb begin
    if (load)       nxt = load_val;
    else if (clear) nxt = '0;
    else if (inc)   nxt = inc16[W-1:0];
    else            nxt = value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end
endmodule

// File: rtl/cyc_start_gen.sv
module cyc_start_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_master,
  input  logic adv,
  input  logic root,
  output logic master_q,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      master_q <= 1'b0;
    else if (ctl_wr) master_q <= ctl_master;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= adv & master_q & root;
  end
endmodule

// File: rtl/isoc_cycle_timer.sv
module isoc_cycle_timer
  import cyc_timer_pkg::*;
#(
  parameter int OFF_W      = 12,
  parameter int OFF_MAX    = 3071,
  parameter int CNT_W      = 13,
  parameter int CNT_MAX    = 7999,
  parameter int SEC_W      = 7,
  parameter int SYNC_STAGE = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tmr_en,
  input  logic                         ext_src_sel,
  input  logic                         ext_cycle,
  input  logic                         root,
  input  logic                         ctl_wr,
  input  logic                         ctl_master,
  input  logic                         host_wr,
  input  logic [OFF_W+CNT_W+SEC_W-1:0] host_wdata,
  output logic [OFF_W+CNT_W+SEC_W-1:0] cyc_time,
  output logic                         cycle_start_req
);
  localparam int TW      = OFF_W + CNT_W + SEC_W;
  localparam int SEC_MAX = (1 << SEC_W) - 1;
  localparam int CNT_LO  = OFF_W;
  localparam int SEC_LO  = OFF_W + CNT_W;

  // Named internal events, brought out for the checker.
  logic     ext_rise;
  logic     ext_adv;
  logic     roll_adv;
  logic     adv;
  logic     sec_adv;
  logic     master_q;
  adv_src_e adv_src;

  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;
  logic             off_max, cnt_max, sec_max_unused;

  cyc_edge_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_cycle),
    .rise     (ext_rise)
  );

  assign ext_adv  = ext_src_sel & ext_rise;
  assign roll_adv = ~ext_src_sel & tmr_en & off_max;
  assign adv      = (ext_adv | roll_adv) & ~host_wr;
  assign sec_adv  = adv & cnt_max;

  always_comb begin
    if (host_wr)       adv_src = ADV_LOAD;
    else if (ext_adv)  adv_src = ADV_EXT;
    else if (roll_adv) adv_src = ADV_ROLL;
    else               adv_src = ADV_NONE;
  end

  cyc_field_ctr #(.W(OFF_W), .MAX(OFF_MAX)) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_wr),
    .load_val (host_wdata[OFF_W-1:0]),
    .clear    (adv_src == ADV_EXT),
    .inc      (tmr_en),
    .value    (off_q),
    .at_max   (off_max)
  );

  cyc_field_ctr #(.W(CNT_W), .MAX(CNT_MAX)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_wr),
    .load_val (host_wdata[SEC_LO-1:CNT_LO]),
    .clear    (1'b0),
    .inc      (adv),
    .value    (cnt_q),
    .at_max   (cnt_max)
  );

  cyc_field_ctr #(.W(SEC_W), .MAX(SEC_MAX)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_wr),
    .load_val (host_wdata[TW-1:SEC_LO]),
    .clear    (1'b0),
    .inc      (sec_adv),
    .value    (sec_q),
    .at_max   (sec_max_unused)
  );

  cyc_start_gen u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_master (ctl_master),
    .adv        (adv),
    .root       (root),
    .master_q   (master_q),
    .req        (cycle_start_req)
  );

  assign cyc_time = {sec_q, cnt_q, off_q};
endmodule

// File: rtl/isoc_cycle_timer_chk.sv
module isoc_cycle_timer_chk #(
  parameter int OFF_W   = 12,
  parameter int OFF_MAX = 3071,
  parameter int CNT_W   = 13,
  parameter int CNT_MAX = 7999,
  parameter int TW      = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_en,
  input logic          host_wr,
  input logic [TW-1:0] host_wdata,
  input logic          ctl_wr,
  input logic          root,
  input logic [TW-1:0] cyc_time,
  input logic          cycle_start_req,
  input logic          master_q,
  input logic          ext_adv
);
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !host_wr && !ext_adv) |=> $stable(cyc_time[OFF_W-1:0])); // R1

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_time[OFF_W-1:0] <= OFF_W'(OFF_MAX)); // R2

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_time[OFF_W+CNT_W-1:OFF_W] <= CNT_W'(CNT_MAX)); // R5

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (cyc_time == $past(host_wdata)) && !cycle_start_req); // R6

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_req |=> !cycle_start_req); // R7

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_start_req) |-> ($past(root) && $past(master_q))); // R7

  AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(master_q)); // R8
endmodule

bind isoc_cycle_timer isoc_cycle_timer_chk #(
  .OFF_W(OFF_W), .OFF_MAX(OFF_MAX), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .TW(TW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tmr_en          (tmr_en),
  .host_wr         (host_wr),
  .host_wdata      (host_wdata),
  .ctl_wr          (ctl_wr),
  .root            (root),
  .cyc_time        (cyc_time),
  .cycle_start_req (cycle_start_req),
  .master_q        (master_q),
  .ext_adv         (ext_adv)
);

// File: tb/isoc_cycle_timer_bench.sv
module isoc_cycle_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0, ext_src_sel = 1'b0, ext_cycle = 1'b0, root = 1'b0;
  logic        ctl_wr = 1'b0, ctl_master = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] cyc_time;
  logic        cycle_start_req;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  isoc_cycle_timer u_isoc_cycle_timer (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .ext_src_sel(ext_src_sel),
    .ext_cycle(ext_cycle), .root(root), .ctl_wr(ctl_wr), .ctl_master(ctl_master),
    .host_wr(host_wr), .host_wdata(host_wdata), .cyc_time(cyc_time),
    .cycle_start_req(cycle_start_req)
  );

  // Bench's own field layout: seconds in 31:25, count in 24:12, offset in 11:0.
  function automatic logic [31:0] tm(input int sec, input int cnt, input int off);
    tm = 32'(sec) << 25 | 32'(cnt) << 12 | 32'(off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] v);
    host_wr = 1'b1; host_wdata = v; tick(1); host_wr = 1'b0;
  endtask

  task automatic set_master(input logic m);
    ctl_wr = 1'b1; ctl_master = m; tick(1); ctl_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 time", cyc_time, 32'd0);
    chk("R9 req", {31'd0, cycle_start_req}, 32'd0);
  endtask

  task automatic t_enable;
    tmr_en = 1'b0; load(tm(3, 10, 100));
    chk("R6 load", cyc_time, tm(3, 10, 100));
    tick(5);
    chk("R1 hold", cyc_time, tm(3, 10, 100));
    tmr_en = 1'b1; tick(7);
    chk("R1 step", cyc_time, tm(3, 10, 107));
  endtask

  task automatic t_roll_internal;
    ext_src_sel = 1'b0; root = 1'b1; tmr_en = 1'b1;
    load(tm(1, 5, 3070));
    tick(1);
    chk("R2 at max", cyc_time, tm(1, 5, 3071));
    chk("R7 no req early", {31'd0, cycle_start_req}, 32'd0);
    tick(1);
    chk("R2 wrap", cyc_time, tm(1, 6, 0));
    chk("R7 req with count", {31'd0, cycle_start_req}, 32'd1);
    tick(1);
    chk("R7 one clock", {31'd0, cycle_start_req}, 32'd0);
  endtask

  task automatic t_seconds;
    tmr_en = 1'b1; ext_src_sel = 1'b0;
    load(tm(5, 7999, 3071)); tick(1);
    chk("R5 carry", cyc_time, tm(6, 0, 0));
    load(tm(127, 7999, 3071)); tick(1);
    chk("R5 seconds wrap", cyc_time, tm(0, 0, 0));
  endtask

  task automatic t_external;
    tmr_en = 1'b1; ext_src_sel = 1'b1; ext_cycle = 1'b0; tick(4);
    load(tm(2, 20, 3071)); tick(1);
    chk("R3 wrap no count", cyc_time, tm(2, 20, 0));
    ext_cycle = 1'b1; tick(2);
    chk("R3 latency", cyc_time, tm(2, 20, 2));
    tick(1);
    chk("R3 edge", cyc_time, tm(2, 21, 0));
    chk("R7 ext req", {31'd0, cycle_start_req}, 32'd1);
    tick(10);
    chk("R4 held high", cyc_time, tm(2, 21, 10));
    ext_cycle = 1'b0; tick(4); ext_cycle = 1'b1; tick(3);
    chk("R3 second edge", cyc_time, tm(2, 22, 0));
    ext_cycle = 1'b0; tick(4);
    ext_src_sel = 1'b0; load(tm(0, 30, 100));
    ext_cycle = 1'b1; tick(6); ext_cycle = 1'b0;
    chk("R3 ignored internal", cyc_time, tm(0, 30, 106));
  endtask

  task automatic t_gating;
    int seen;
    tmr_en = 1'b1; ext_src_sel = 1'b0;
    root = 1'b0; load(tm(0, 50, 3069)); seen = 0;
    for (int i = 0; i < 5; i++) begin tick(1); seen += int'(cycle_start_req); end
    chk("R7 root low", 32'(seen), 32'd0);
    chk("R7 count still", cyc_time, tm(0, 51, 2));
    root = 1'b1; set_master(1'b0); load(tm(0, 60, 3069)); seen = 0;
    for (int i = 0; i < 5; i++) begin tick(1); seen += int'(cycle_start_req); end
    chk("R8 master cleared", 32'(seen), 32'd0);
    set_master(1'b1); load(tm(0, 7999, 3071));
    load(tm(0, 7999, 3069)); seen = 0;
    for (int i = 0; i < 5; i++) begin tick(1); seen += int'(cycle_start_req); end
    chk("R8 master kept", 32'(seen), 32'd1);
  endtask

  task automatic t_priority;
    tmr_en = 1'b1; ext_src_sel = 1'b0; root = 1'b1;
    load(tm(0, 40, 3071));
    load(tm(9, 100, 3071));
    chk("R6 priority", cyc_time, tm(9, 100, 3071));
    chk("R6 no req", {31'd0, cycle_start_req}, 32'd0);
    tick(1);
    chk("R6 then wrap", cyc_time, tm(9, 101, 0));
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(2);
    t_reset();
    t_enable();
    set_master(1'b1);
    t_roll_internal();
    t_seconds();
    t_external();
    t_gating();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule